// File: doc/BRIEF.md
# Predecoded Word and Byte-Lane Strobe Decoder

This block decodes the address and control inputs of a single-port memory that holds 256 words of 32 bits. It produces one write strobe per byte lane of every word. Each strobe is meant to drive the select of a hold-or-load multiplexer in front of that byte's eight storage flops. The block also produces a registered one-hot read select and a registered copy of the address, which the read path uses one cycle later. The storage array, the read multiplexer and the output drivers sit outside this block.

The word decode is hierarchical rather than a flat compare:
- Every 2-bit slice of the address is predecoded into four active-low lines.
- The predecodes of the low half and the high half of the address are merged into two groups of active-high lines.
- Each word line is the NAND of one line from each group, so it is active low.
- A byte strobe is the NOR of the active-low word line, the inverted chip enable and the inverted lane enable.

The read select flops capture the inverted word lines on every rising edge. The address register loads only while chip enable is high.

Top module: `word_strobe_decoder`

## Requirements
- R1: With `ce` high, strobe bit `w*4+b` of `wr_strobe` is 1 exactly when `addr` equals `w` and `we[b]` is 1. The strobe follows the inputs in the same cycle, without a clock edge.
- R2: With `ce` low, every bit of `wr_strobe` is 0, whatever the values of `addr` and `we`.
- R3: The number of set bits in `wr_strobe` equals the number of set bits in `we` when `ce` is high, and is 0 otherwise. The lanes are enabled independently of one another.
- R4: On a rising edge with `ce` high and `rst` low, `rd_addr` takes the value of `addr`.
- R5: On a rising edge with `ce` low and `rst` low, `rd_addr` keeps its value.
- R6: On every rising edge with `rst` low, `rd_sel` becomes one-hot with bit `addr` set, whether `ce` is high or low.
- R7: A rising edge with `rst` high clears both `rd_sel` and `rd_addr` to 0.
- R8: Exactly one internal active-low word line is asserted for any address value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the registered outputs, active high |
| ce | input | 1 | Chip enable, active high |
| we | input | 4 | Byte-lane write enables, bit b selects lane b |
| addr | input | 8 | Word address |
| wr_strobe | output | 1024 | Write strobe, bit w*4+b is lane b of word w |
| rd_sel | output | 256 | Registered one-hot read select |
| rd_addr | output | 8 | Registered address, loaded while ce is high |

## Verification
The bound checker checks the following on every cycle:
- the internal word lines stay exactly one-hot;
- the lane of strobes at the current address mirrors `we` under `ce`;
- the strobe count matches the enable count;
- the next-cycle behaviour of `rd_addr` and `rd_sel`.

Only the bench's scenarios can show the remaining behaviour. That covers that no strobe outside the addressed word ever fires, across all 256 addresses and all 32 combinations of `ce` and `we`. It also covers the clearing effect of reset, both at start-up and in the middle of a run with `ce` high.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  localparam int SLICE_W     = 2;
  localparam int SLICE_LINES = 1 << SLICE_W;

  // Flat index of the strobe for one lane of one word.
  function automatic int strobe_pos(input int word, input int lane, input int lanes);
    return word * lanes + lane;
  endfunction

  // Number of lines produced by merging a count of 2-bit slices.
  function automatic int group_lines(input int slices);
    return 1 << (SLICE_W * slices);
  endfunction
endpackage

// File: rtl/wsd_predec2.sv
module wsd_predec2
  import wsd_pkg::*;
(
  input  logic [SLICE_W-1:0]     slice,
  output logic [SLICE_LINES-1:0] line_n
);
  for (genvar v = 0; v < SLICE_LINES; v++) begin : g_line
    localparam logic [1:0] VAL = v[1:0];
    logic bit0, bit1;
    assign bit0 = VAL[0] ? slice[0] : ~slice[0];
    assign bit1 = VAL[1] ? slice[1] : ~slice[1];
    assign line_n[v] = ~(bit0 & bit1);
  end
endmodule

// File: rtl/wsd_group.sv
module wsd_group
  import wsd_pkg::*;
#(
  parameter int SLICES = 2
) (
  input  logic [SLICES*SLICE_LINES-1:0]   pre_n,
  output logic [group_lines(SLICES)-1:0]  grp
);
  localparam int LINES = group_lines(SLICES);

  for (genvar j = 0; j < LINES; j++) begin : g_line
    logic [SLICES-1:0] pick_n;
    for (genvar f = 0; f < SLICES; f++) begin : g_slice
      assign pick_n[f] = pre_n[f*SLICE_LINES + ((j >> (SLICE_W*f)) % SLICE_LINES)];
    end
    assign grp[j] = ~|pick_n;
  end
endmodule

// File: rtl/wsd_wordline.sv
module wsd_wordline #(
  parameter int LO_N = 16,
  parameter int HI_N = 16
) (
  input  logic [LO_N-1:0]      lo,
  input  logic [HI_N-1:0]      hi,
  output logic [LO_N*HI_N-1:0] word_n
);
  for (genvar h = 0; h < HI_N; h++) begin : g_hi
    for (genvar l = 0; l < LO_N; l++) begin : g_lo
      assign word_n[h*LO_N + l] = ~(lo[l] & hi[h]);
    end
  end
endmodule

// File: rtl/word_strobe_decoder.sv
module word_strobe_decoder
  import wsd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ce,
  input  logic [LANES-1:0]                we,
  input  logic [ADDR_W-1:0]               addr,
  output logic [(LANES<<ADDR_W)-1:0]      wr_strobe,
  output logic [(1<<ADDR_W)-1:0]          rd_sel,
  output logic [ADDR_W-1:0]               rd_addr
);
  localparam int WORDS   = 1 << ADDR_W;
  localparam int NSLICES = ADDR_W / SLICE_W;
  localparam int LO_S    = NSLICES / 2;
  localparam int HI_S    = NSLICES - LO_S;
  localparam int LO_N    = group_lines(LO_S);
  localparam int HI_N    = group_lines(HI_S);

  logic [NSLICES*SLICE_LINES-1:0] pre_n;
  logic [LO_N-1:0]                grp_lo;
  logic [HI_N-1:0]                grp_hi;
  logic [WORDS-1:0]               word_n;
  logic [WORDS-1:0]               rd_sel_d;
  logic                           ce_n;
  logic [LANES-1:0]               we_n;

  for (genvar s = 0; s < NSLICES; s++) begin : g_pre
    wsd_predec2 u_pre (
      .slice  (addr[s*SLICE_W +: SLICE_W]),
      .line_n (pre_n[s*SLICE_LINES +: SLICE_LINES])
    );
  end

  wsd_group #(.SLICES(LO_S)) u_grp_lo (
    .pre_n (pre_n[LO_S*SLICE_LINES-1:0]),
    .grp   (grp_lo)
  );

  wsd_group #(.SLICES(HI_S)) u_grp_hi (
    .pre_n (pre_n[NSLICES*SLICE_LINES-1:LO_S*SLICE_LINES]),
    .grp   (grp_hi)
  );

  wsd_wordline #(.LO_N(LO_N), .HI_N(HI_N)) u_words (
    .lo     (grp_lo),
    .hi     (grp_hi),
    .word_n (word_n)
  );

  assign ce_n     = ~ce;
  assign we_n     = ~we;
  assign rd_sel_d = ~word_n;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign wr_strobe[strobe_pos(w, b, LANES)] = ~(word_n[w] | ce_n | we_n[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr <= '0;
      rd_sel  <= '0;
    end else begin
      if (ce) rd_addr <= addr;
      rd_sel <= rd_sel_d;
    end
  end
endmodule

module wsd_checker #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ce,
  input logic [LANES-1:0]           we,
  input logic [ADDR_W-1:0]          addr,
  input logic [(1<<ADDR_W)-1:0]     word_n,
  input logic [(LANES<<ADDR_W)-1:0] wr_strobe,
  input logic [(1<<ADDR_W)-1:0]     rd_sel,
  input logic [ADDR_W-1:0]          rd_addr
);
  // R8
  word_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~word_n) == 1);

  // R1
  lane_match_chk: assert property (@(posedge clk) disable iff (rst)
    ce |-> (wr_strobe[addr*LANES +: LANES] == we));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |-> (wr_strobe == '0));

  // R3
  strobe_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_strobe) == (ce ? $countones(we) : 0));

  // R4
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (rd_addr == $past(addr)));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(rd_addr));

  // R6
  read_sel_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_sel[$past(addr)] && $countones(rd_sel) == 1));
endmodule

bind word_strobe_decoder wsd_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wsd_checker (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .we        (we),
  .addr      (addr),
  .word_n    (word_n),
  .wr_strobe (wr_strobe),
  .rd_sel    (rd_sel),
  .rd_addr   (rd_addr)
);

// File: tb/test_word_strobe_decoder.sv
module test_word_strobe_decoder;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int NW = 1 << AW;
  localparam int NS = NW * LN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce  = 1'b0;
  logic [LN-1:0] we  = '0;
  logic [AW-1:0] addr = '0;
  logic [NS-1:0] wr_strobe;
  logic [NW-1:0] rd_sel;
  logic [AW-1:0] rd_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [AW-1:0] model_ra = '0;

  always #5 clk = ~clk;

  word_strobe_decoder #(.ADDR_W(AW), .LANES(LN)) i_word_strobe_decoder (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr),
    .wr_strobe(wr_strobe), .rd_sel(rd_sel), .rd_addr(rd_addr)
  );

  function automatic logic [NS-1:0] exp_strobes(input int a, input bit c, input logic [LN-1:0] e);
    logic [NS-1:0] v = '0;
    if (c) for (int k = 0; k < LN; k++) v[a*LN + k] = e[k];
    return v;
  endfunction

  function automatic int ones(input logic [LN-1:0] e);
    int n = 0;
    for (int k = 0; k < LN; k++) n += e[k];
    return n;
  endfunction

  task automatic check_vec(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R7 reset state
    check_vec("R7 rd_sel after reset", NS'(rd_sel), '0);
    check_int("R7 rd_addr after reset", int'(rd_addr), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int a = 0; a < NW; a++) begin
      for (int c = 0; c < 2; c++) begin
        for (int e = 0; e < (1 << LN); e++) begin
          @(negedge clk);
          addr = AW'(a);
          ce   = c[0];
          we   = LN'(e);
          #1;
          if (c != 0) check_vec("R1 strobe pattern", wr_strobe, exp_strobes(a, 1'b1, LN'(e)));
          else        check_vec("R2 strobes idle", wr_strobe, '0);
          check_int("R3 strobe count", $countones(wr_strobe), (c != 0) ? ones(LN'(e)) : 0);
          @(posedge clk);
          if (c != 0) model_ra = AW'(a);
          #1;
          check_vec("R6 read select", NS'(rd_sel), NS'({{(NW-1){1'b0}}, 1'b1} << a));
          if (c != 0) check_int("R4 address load", int'(rd_addr), int'(model_ra));
          else        check_int("R5 address hold", int'(rd_addr), int'(model_ra));
        end
      end
    end

    // R7 reset mid-run overrides a load with ce high
    @(negedge clk);
    addr = 8'h5A; ce = 1'b1; we = 4'hF; rst = 1'b1;
    @(posedge clk);
    #1;
    check_vec("R7 rd_sel cleared", NS'(rd_sel), '0);
    check_int("R7 rd_addr cleared", int'(rd_addr), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_int("R4 load after reset", int'(rd_addr), 8'h5A);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule